// File: doc/BRIEF.md
# Upstream transmit microsequencer

This block produces the upstream burst payload. When the slot-start pulse from the transmit timing counter arrives, it runs a short program held in an instruction memory. Each instruction names a source, a start address and a byte count. It also carries two flags: one replays the range a second time, and one marks the bytes for scrambling. The sequencer reads the bytes from the queue data memories at the moment they are sent, so no complete frame is ever assembled in a buffer. Header and check-code positions are instruction sources like any other. At those positions the sequencer strobes the matching encoder lane and forwards the byte that the lane returns.

The block issues one read per cycle while a program runs. It fetches the next instruction during the final beat of the current one and uses the fetched word in the cycle it arrives, so consecutive sequences are sent without idle cycles between them. A zero-length instruction ends the program and pulses `done`. The scramble marking travels beside each byte, and the scrambler downstream acts on it.

Top module: `upseq_top`

## Requirements
- R1: While reset is high and afterwards until a slot starts, `out_valid`, `done`, `imem_rd`, every `dmem_rd` bit and every `enc_rd` bit are low.
- R2: A `slot_start` pulse seen while idle reads instruction address 0, and the first byte of a non-empty program is valid two cycles after the cycle in which `slot_start` was high.
- R3: An instruction word is 23 bits: start address in bits 9:0, length in bits 17:10, scramble flag in bit 18, repeat flag in bit 19 and source code in bits 22:20. Source codes 0 to 3 select a queue memory and codes 4 to 6 select encoder lanes 0 to 2.
- R4: For a queue source, byte i of the sequence is the content of that queue at (start + i) modulo 1024. The read strobe and address are driven in one cycle and the byte appears on `out_byte` in the next.
- R5: With the repeat flag set, the whole address range is sent a second time before the next instruction runs.
- R6: `out_scr` carries the scramble flag of the instruction that produced each valid byte, and the byte value itself is not altered.
- R7: For an encoder source, each byte strobes `enc_rd` of that lane once, and the byte the lane presents in the following cycle is forwarded.
- R8: From the first valid byte to the last, `out_valid` stays high continuously, including across instruction boundaries.
- R9: A zero-length instruction ends the program. `done` is high for exactly one cycle, in the cycle after the last valid byte (or two cycles after `slot_start` for an empty program), and is never high together with `out_valid`.
- R10: A `slot_start` pulse during execution has no effect on the byte stream.
- R11: `out_src` reports the source code of every valid byte.
- R12: A later slot runs the program again from instruction address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Transmission time reached |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_addr | output | 5 | Instruction address |
| imem_rdata | input | 23 | Instruction word, one cycle after the read |
| dmem_rd | output | 4 | Per-queue read strobe |
| dmem_addr | output | 10 | Shared queue read address |
| dmem_rdata | input | 32 | Queue read data, 8 bits per queue, queue 0 in the low byte |
| enc_rd | output | 3 | Per-encoder-lane byte request |
| enc_data | input | 24 | Encoder lane bytes, lane 0 in the low byte, one cycle after the request |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_scr | output | 1 | Scramble enable for this byte |
| out_src | output | 3 | Source code of this byte |
| done | output | 1 | Program finished, one-cycle pulse |

## Verification
The bench builds the block with the package defaults: four queues, three encoder lanes, 10-bit data addresses, 8-bit lengths and a 32-word program. With 10-bit addresses, a sequence that starts at 1020 wraps to the bottom of a queue. With 8-bit lengths, a repeated 255-byte run is 510 back-to-back beats. The 32-word program leaves room for random lists of up to eight instructions that mix every source code with both flags. Directed lists cover an empty program, one-byte sequences with and without repeat, and a second slot pulse in the middle of a run.

// File: rtl/upseq_pkg.sv
package upseq_pkg;
    localparam int unsigned NQ   = 4;
    localparam int unsigned NENC = 3;
    localparam int unsigned AW   = 10;
    localparam int unsigned LW   = 8;
    localparam int unsigned PCW  = 5;
    localparam int unsigned BW   = 8;
    localparam int unsigned SRCW = $clog2(NQ + NENC);

    typedef logic [SRCW-1:0] src_t;

    typedef struct packed {
        src_t            src;
        logic            rep;
        logic            scr;
        logic [LW-1:0]   len;
        logic [AW-1:0]   addr;
    } ins_t;

    localparam int unsigned INSW = $bits(ins_t);

    typedef enum logic [0:0] {ST_IDLE, ST_RUN} st_t;

    typedef struct packed {
        logic vld;
        logic scr;
        src_t src;
    } side_t;

    function automatic logic src_is_queue(src_t s, int unsigned q);
        return int'(s) == int'(q);
    endfunction

    function automatic logic src_is_enc(src_t s, int unsigned e);
        return int'(s) == int'(NQ + e);
    endfunction
endpackage

// File: rtl/upseq_ctrl.sv
module upseq_ctrl
    import upseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_start,
    output logic            imem_rd,
    output logic [PCW-1:0]  imem_addr,
    input  ins_t            imem_word,
    output logic            iss_vld,
    output logic [AW-1:0]   iss_addr,
    output src_t            iss_src,
    output logic            iss_scr,
    output logic            done
);
    st_t            st;
    logic [PCW-1:0] pc;
    ins_t           cur;
    logic [LW-1:0]  cnt;
    logic           pass;
    logic           fetched;

    ins_t           eff;
    logic [LW-1:0]  ecnt;
    logic           epass;
    logic           term;
    logic           seq_end;
    logic           last;

    // The freshly fetched word bypasses the register so its first beat issues at once.
    always_comb begin
        eff      = fetched ? imem_word : cur;
        ecnt     = fetched ? '0 : cnt;
        epass    = fetched ? 1'b0 : pass;
        term     = (st == ST_RUN) && fetched && (imem_word.len == '0);
        iss_vld  = (st == ST_RUN) && !term;
        iss_addr = eff.addr + AW'(ecnt);
        iss_src  = eff.src;
        iss_scr  = eff.scr;
        seq_end  = (ecnt == eff.len - LW'(1));
        last     = iss_vld && seq_end && (epass || !eff.rep);
        imem_rd  = ((st == ST_IDLE) && slot_start) || last;
        imem_addr = (st == ST_IDLE) ? '0 : pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pc      <= '0;
            cur     <= '0;
            cnt     <= '0;
            pass    <= 1'b0;
            fetched <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= term;
            unique case (st)
                ST_IDLE: begin
                    if (slot_start) begin
                        st      <= ST_RUN;
                        pc      <= PCW'(1);
                        fetched <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (term) begin
                        st      <= ST_IDLE;
                        fetched <= 1'b0;
                    end else begin
                        cur <= eff;
                        if (last) begin
                            fetched <= 1'b1;
                            pc      <= pc + PCW'(1);
                        end else begin
                            fetched <= 1'b0;
                            if (seq_end) begin
                                cnt  <= '0;
                                pass <= 1'b1;
                            end else begin
                                cnt  <= ecnt + LW'(1);
                                pass <= epass;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_issues_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && slot_start) |=> (iss_vld || term));

    assert_midrun_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && slot_start && !last && !term) |=> !fetched);
endmodule

// File: rtl/upseq_rdport.sv
module upseq_rdport
    import upseq_pkg::*;
(
    input  logic            iss_vld,
    input  logic [AW-1:0]   iss_addr,
    input  src_t            iss_src,
    output logic [NQ-1:0]   dmem_rd,
    output logic [AW-1:0]   dmem_addr,
    output logic [NENC-1:0] enc_rd
);
    assign dmem_addr = iss_addr;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign dmem_rd[q] = iss_vld && src_is_queue(iss_src, q);
    end

    for (genvar e = 0; e < NENC; e++) begin : g_e
        assign enc_rd[e] = iss_vld && src_is_enc(iss_src, e);
    end
endmodule

// File: rtl/upseq_outmux.sv
module upseq_outmux
    import upseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               iss_vld,
    input  src_t               iss_src,
    input  logic               iss_scr,
    input  logic [NQ*BW-1:0]   dmem_rdata,
    input  logic [NENC*BW-1:0] enc_data,
    input  logic               done,
    output logic               out_valid,
    output logic [BW-1:0]      out_byte,
    output logic               out_scr,
    output src_t               out_src
);
    side_t sd;

    // Sideband follows the read by one cycle, matching the memory latency.
    always_ff @(posedge clk) begin
        if (rst) sd <= '0;
        else     sd <= '{vld: iss_vld, scr: iss_scr, src: iss_src};
    end

    always_comb begin
        out_byte = '0;
        for (int q = 0; q < int'(NQ); q++)
            if (sd.vld && src_is_queue(sd.src, q)) out_byte = dmem_rdata[q*BW +: BW];
        for (int e = 0; e < int'(NENC); e++)
            if (sd.vld && src_is_enc(sd.src, e)) out_byte = enc_data[e*BW +: BW];
    end

    assign out_valid = sd.vld;
    assign out_scr   = sd.vld && sd.scr;
    assign out_src   = sd.src;

    assert_stream_ends_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> done);

    assert_done_not_with_byte_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);
endmodule

// File: rtl/upseq_top.sv
module upseq_top
    import upseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_start,
    output logic               imem_rd,
    output logic [PCW-1:0]     imem_addr,
    input  logic [INSW-1:0]    imem_rdata,
    output logic [NQ-1:0]      dmem_rd,
    output logic [AW-1:0]      dmem_addr,
    input  logic [NQ*BW-1:0]   dmem_rdata,
    output logic [NENC-1:0]    enc_rd,
    input  logic [NENC*BW-1:0] enc_data,
    output logic               out_valid,
    output logic [BW-1:0]      out_byte,
    output logic               out_scr,
    output logic [SRCW-1:0]    out_src,
    output logic               done
);
    ins_t          word;
    logic          iss_vld;
    logic [AW-1:0] iss_addr;
    src_t          iss_src;
    logic          iss_scr;

    assign word = ins_t'(imem_rdata);

    upseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .slot_start(slot_start),
        .imem_rd   (imem_rd),
        .imem_addr (imem_addr),
        .imem_word (word),
        .iss_vld   (iss_vld),
        .iss_addr  (iss_addr),
        .iss_src   (iss_src),
        .iss_scr   (iss_scr),
        .done      (done)
    );

    upseq_rdport u_rdport (
        .iss_vld  (iss_vld),
        .iss_addr (iss_addr),
        .iss_src  (iss_src),
        .dmem_rd  (dmem_rd),
        .dmem_addr(dmem_addr),
        .enc_rd   (enc_rd)
    );

    upseq_outmux u_outmux (
        .clk       (clk),
        .rst       (rst),
        .iss_vld   (iss_vld),
        .iss_src   (iss_src),
        .iss_scr   (iss_scr),
        .dmem_rdata(dmem_rdata),
        .enc_data  (enc_data),
        .done      (done),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_scr   (out_scr),
        .out_src   (out_src)
    );
endmodule

// File: tb/upseq_top_test.sv
module upseq_top_test;
    import upseq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               slot_start = 1'b0;
    logic               imem_rd;
    logic [PCW-1:0]     imem_addr;
    logic [INSW-1:0]    imem_rdata;
    logic [NQ-1:0]      dmem_rd;
    logic [AW-1:0]      dmem_addr;
    logic [NQ*BW-1:0]   dmem_rdata;
    logic [NENC-1:0]    enc_rd;
    logic [NENC*BW-1:0] enc_data;
    logic               out_valid;
    logic [BW-1:0]      out_byte;
    logic               out_scr;
    logic [SRCW-1:0]    out_src;
    logic               done;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upseq_top uut (.*);

    // Memory and encoder models
    logic [INSW-1:0] im [32];
    logic [7:0]      dm [NQ][1024];
    logic [7:0]      dq [NQ];
    logic [7:0]      eq [NENC];
    int              ecnt [NENC];

    function automatic logic [7:0] enc_val(int e, int n);
        return 8'(e * 64 + n * 7 + 3);
    endfunction

    initial begin
        for (int e = 0; e < int'(NENC); e++) begin ecnt[e] = 0; eq[e] = '0; end
        for (int q = 0; q < int'(NQ); q++) dq[q] = '0;
        imem_rdata = '0;
    end

    always @(posedge clk) begin
        if (imem_rd) imem_rdata <= im[imem_addr];
        for (int q = 0; q < int'(NQ); q++)
            if (dmem_rd[q]) dq[q] <= dm[q][dmem_addr];
        for (int e = 0; e < int'(NENC); e++)
            if (enc_rd[e]) begin
                eq[e]   <= enc_val(e, ecnt[e]);
                ecnt[e] <= ecnt[e] + 1;
            end
    end

    always_comb begin
        for (int q = 0; q < int'(NQ); q++) dmem_rdata[q*8 +: 8] = dq[q];
        for (int e = 0; e < int'(NENC); e++) enc_data[e*8 +: 8] = eq[e];
    end

    function automatic logic [INSW-1:0] mk(int src, bit rep, bit scr, int len, int addr);
        return {3'(src), rep, scr, 8'(len), 10'(addr)};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected stream, computed from the requirements
    logic [7:0] xb[$];
    logic       xs[$];
    int         xsrc[$];
    int         xk[$];   // 4: queue first pass, 5: repeat pass, 7: encoder

    task automatic build_exp();
        int ec [NENC];
        xb.delete(); xs.delete(); xsrc.delete(); xk.delete();
        for (int e = 0; e < int'(NENC); e++) ec[e] = ecnt[e];
        for (int p = 0; p < 32; p++) begin
            logic [INSW-1:0] w;
            int src, len, addr;
            bit rep, scr;
            w = im[p];
            addr = int'(w[9:0]); len = int'(w[17:10]);
            scr = w[18]; rep = w[19]; src = int'(w[22:20]);
            if (len == 0) break;
            for (int ps = 0; ps <= int'(rep); ps++)
                for (int i = 0; i < len; i++) begin
                    if (src < int'(NQ)) begin
                        xb.push_back(dm[src][(addr + i) % 1024]);
                        xk.push_back(ps == 0 ? 4 : 5);
                    end else begin
                        xb.push_back(enc_val(src - int'(NQ), ec[src - int'(NQ)]));
                        ec[src - int'(NQ)]++;
                        xk.push_back(7);
                    end
                    xs.push_back(scr);
                    xsrc.push_back(src);
                end
        end
    endtask

    task automatic run_slot(int midpulse);
        logic [7:0] gb[$];
        logic       gs[$];
        int         gsrc[$];
        int first, donek;
        bit gap, both;
        build_exp();
        first = -1; donek = -1; gap = 0; both = 0;
        @(negedge clk);
        slot_start = 1'b1;
        for (int k = 1; k < 20000; k++) begin
            @(negedge clk);
            if (k == 1) slot_start = 1'b0;
            if (midpulse != 0 && k == midpulse) slot_start = 1'b1;
            if (midpulse != 0 && k == midpulse + 1) slot_start = 1'b0;
            if (out_valid) begin
                if (first < 0) first = k;
                gb.push_back(out_byte); gs.push_back(out_scr); gsrc.push_back(int'(out_src));
            end else if (first >= 0 && !done) gap = 1;
            if (done) begin
                if (out_valid) both = 1;
                donek = k;
                break;
            end
        end
        slot_start = 1'b0;
        chk(donek > 0, "R9 done reached", donek, 1);
        if (xb.size() > 0) begin
            chk(first == 2, "R2 first byte latency", first, 2);
            chk(donek == first + xb.size(), "R9 done timing", donek, first + xb.size());
        end else begin
            chk(donek == 2, "R9 empty program done timing", donek, 2);
        end
        chk(gb.size() == xb.size(), "R9 byte count", gb.size(), xb.size());
        chk(!gap, "R8 gap in stream", int'(gap), 0);
        chk(!both, "R9 done with valid", int'(both), 0);
        for (int i = 0; i < xb.size() && i < gb.size(); i++) begin
            string t;
            t = (xk[i] == 7) ? "R7 encoder byte" : (xk[i] == 5) ? "R5 repeat byte" : "R4 queue byte";
            chk(gb[i] == xb[i], t, gb[i], xb[i]);
            chk(gs[i] == xs[i], "R6 scramble flag", gs[i], xs[i]);
            chk(gsrc[i] == xsrc[i], "R11 source code", gsrc[i], xsrc[i]);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(out_valid == 1'b0, "R9 idle after done", out_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int q = 0; q < int'(NQ); q++)
            for (int a = 0; a < 1024; a++) dm[q][a] = 8'($urandom);
        for (int p = 0; p < 32; p++) im[p] = '0;

        // R1 reset and idle quiet
        repeat (3) @(negedge clk);
        chk({out_valid, done, imem_rd, |dmem_rd, |enc_rd} == 5'b0, "R1 outputs in reset",
            {out_valid, done, imem_rd, |dmem_rd, |enc_rd}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({out_valid, done, imem_rd, |dmem_rd, |enc_rd} == 5'b0, "R1 idle after reset",
            {out_valid, done, imem_rd, |dmem_rd, |enc_rd}, 0);

        // R9 empty program
        im[0] = '0;
        run_slot(0);

        // R3 R4 R6 single byte, no repeat
        im[0] = mk(0, 0, 1, 1, 5); im[1] = '0;
        run_slot(0);

        // R5 single byte repeated
        im[0] = mk(2, 1, 0, 1, 77); im[1] = '0;
        run_slot(0);

        // R4 wrap, R7 encoders, R5 long repeat, R8 boundaries
        im[0] = mk(4, 0, 0, 4, 0);
        im[1] = mk(3, 1, 1, 8, 1020);
        im[2] = mk(5, 0, 0, 4, 0);
        im[3] = mk(1, 1, 1, 255, 600);
        im[4] = mk(6, 0, 0, 1, 0);
        im[5] = '0;
        run_slot(0);

        // R10 slot pulse mid run; R12 rerun same program from address 0
        run_slot(7);
        run_slot(0);

        // Random programs
        for (int n = 0; n < 20; n++) begin
            int cnt;
            cnt = int'($urandom_range(1, 8));
            for (int p = 0; p < 32; p++) im[p] = '0;
            for (int p = 0; p < cnt; p++)
                im[p] = mk(int'($urandom_range(0, 6)), 1'($urandom), 1'($urandom),
                           int'($urandom_range(1, 40)), int'($urandom_range(0, 1023)));
            run_slot((n % 4 == 0) ? int'($urandom_range(3, 20)) : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule